// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Controller

This block sits on the host side of a byte-wide asynchronous static RAM with 11 address bits and active-low chip-select, output-enable and write-strobe pins. A requester hands it one access at a time over a valid/ready handshake, with an address, write data and a write flag. The controller then runs the pin sequence that the memory needs. It drives the address lines and the three strobes, and it exposes the data bus as a split output/enable/input triple that a pad ring or a bench resolves into a tri-state bus. Each read returns its byte with a one-cycle valid pulse.

All memory timing is given as nanosecond parameters and a clock period parameter. Each interval is turned into a whole number of clock cycles by rounding up, with a floor of one cycle. Writes are timed by the write strobe while output-enable stays high. Between a read and a later write, the controller waits for the bus to be released before it drives the bus. It also holds off new requests until the minimum cycle time has passed since the previous access began.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all three strobes are high, the data drive enable is low, `rd_valid` is low and `req_ready` is high.
- R2: A read holds chip-select and output-enable low with the write strobe high. On the clock edge that raises the strobes, `rd_valid` goes high for exactly one cycle.
- R3: Read data is the bus value sampled on the edge that ends the read access count. A value the memory presents before that count has elapsed is not returned.
- R4: A write holds chip-select and the write strobe low together for N_WL cycles, with output-enable high throughout. N_WL is the largest of the write pulse, address-to-strobe-high and data setup counts, which is 8 cycles at the defaults.
- R5: During a write, the controller drives `sram_dq_out` with the write data, and `sram_dq_oe` is high from the edge where the write strobe falls. The drive continues for N_DH cycles (1 at the defaults) after the strobe rises and then stops.
- R6: `sram_addr` does not change while chip-select is low or the data bus is driven.
- R7: The data bus is never driven while output-enable is low. After a read releases its strobes, at least N_HZ cycles (4 at the defaults) pass before the controller drives the bus.
- R8: `req_ready` is low while an access is in progress. Two accepted requests are always at least N_RC cycles apart (9 at the defaults).
- R9: A request presented while `req_ready` is low waits without effect on the pins. It is carried out exactly once after it is accepted.
- R10: Every nanosecond interval becomes ceil(ns / CLK_PERIOD_NS) cycles, and never fewer than 1. With an 8 ns clock the read access (the larger of 70 ns and 35 ns) takes 9 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` as valid |
| rd_data | output | DATA_W | Byte returned by the last read |
| sram_addr | output | ADDR_W | Memory address lines |
| sram_ce_n | output | 1 | Memory chip-select, active low |
| sram_oe_n | output | 1 | Memory output-enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dq_out | output | DATA_W | Data the controller drives onto the bus |
| sram_dq_oe | output | 1 | High when the controller drives the bus |
| sram_dq_in | input | DATA_W | Resolved bus value seen by the controller |

## Verification
A sequencer left in the wrong state or a phase counter loaded with the wrong value shows up at once as a wrong strobe pulse width. The bench measures every read and write pulse in cycles. A capture taken one edge early returns a byte that the bench memory model has not yet made valid. A turnaround that is too short shows as bus contention with the model, or as a drive-to-release gap below N_HZ, within a few cycles of the write that follows a read. A request that is dropped or duplicated changes the count of chip-select falls, which the bench checks against the number of requests.

// File: rtl/sram_ctrl_pkg.sv
// Shared helpers and types for the asynchronous SRAM cycle controller.
// Assumes all timing inputs are non-negative nanosecond integers.
package sram_ctrl_pkg;

    // Round a nanosecond interval up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_HOLD  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sram_interval_timer.sv
// Loadable down-counter that flags when an interval has run out.
// A load of N-1 on entry gives exactly N cycles before expiry ends the interval.
module sram_interval_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer: accepts one request at a time, walks the read or write
// phases and drives the strobes and the bus drive enable from registers.
// Assumes phase counts already converted to cycles (each >= 1).
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned N_RD  = 9,
    parameter int unsigned N_WL  = 8,
    parameter int unsigned N_DH  = 1,
    parameter int unsigned N_HZ  = 4,
    parameter int unsigned N_RC  = 9,
    parameter int          CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic drive_en
);

    localparam logic [CNT_W-1:0] LD_RD = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] LD_WL = CNT_W'(N_WL - 1);
    localparam logic [CNT_W-1:0] LD_DH = CNT_W'(N_DH - 1);
    localparam logic [CNT_W-1:0] LD_HZ = CNT_W'(N_HZ - 1);
    localparam logic [CNT_W-1:0] LD_RC = CNT_W'(N_RC - 1);

    seq_state_e       state_q, state_d;
    logic             ph_load;
    logic [CNT_W-1:0] ph_val;
    logic             ph_exp;
    logic             cyc_exp;

    // Phase timer: length of the current read/write/turnaround phase.
    sram_interval_timer #(.CNT_W(CNT_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_exp)
    );

    // Cycle timer: minimum spacing between access starts.
    sram_interval_timer #(.CNT_W(CNT_W)) u_cycle_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (LD_RC),
        .expired  (cyc_exp)
    );

    assign req_ready = (state_q == ST_IDLE) && cyc_exp;
    assign accept    = req_valid && req_ready;

    // Next-state and phase-timer load selection.
    always_comb begin
        state_d = state_q;
        ph_load = 1'b0;
        ph_val  = '0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    ph_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_PULSE;
                        ph_val  = LD_WL;
                    end else begin
                        state_d = ST_RD_ACC;
                        ph_val  = LD_RD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (ph_exp) begin
                    state_d = ST_RD_TURN;
                    ph_load = 1'b1;
                    ph_val  = LD_HZ;
                    capture = 1'b1;
                end
            end
            ST_RD_TURN: begin
                if (ph_exp)
                    state_d = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (ph_exp) begin
                    state_d = ST_WR_HOLD;
                    ph_load = 1'b1;
                    ph_val  = LD_DH;
                end
            end
            ST_WR_HOLD: begin
                if (ph_exp)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and glitch-free registered pin controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ce_n     <= 1'b1;
            oe_n     <= 1'b1;
            we_n     <= 1'b1;
            drive_en <= 1'b0;
        end else begin
            state_q  <= state_d;
            ce_n     <= !((state_d == ST_RD_ACC) || (state_d == ST_WR_PULSE));
            oe_n     <= !(state_d == ST_RD_ACC);
            we_n     <= !(state_d == ST_WR_PULSE);
            drive_en <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
        end
    end

    AST_NO_DRIVE_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> oe_n); // R7
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !ce_n)); // R4
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ce_n && oe_n && we_n && !drive_en)); // R8
    AST_DRIVE_AT_WE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> drive_en); // R5
    AST_DRIVE_AFTER_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> drive_en); // R5

endmodule

// File: rtl/sram_bus_port.sv
// Data-path side of the controller: latches address and write data on
// acceptance, presents them to the pins, and captures read data on request.
// Assumes capture is a one-cycle pulse issued by the sequencer.
module sram_bus_port #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic              ce_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    // Hold address and write data from acceptance until the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the bus at the end of the read access and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_data <= dq_in;
        end
    end

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(addr_q)); // R6
    AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R2

endmodule

// File: rtl/sram_cycle_ctrl.sv
// Top of the asynchronous SRAM cycle controller. Converts nanosecond timing
// parameters to cycle counts and wires the sequencer to the data path.
// Assumes a single requester and a single byte-wide memory on the bus.
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int          ADDR_W        = 11,
    parameter int          DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned T_ACC_NS      = 70,
    parameter int unsigned T_OE_ACC_NS   = 35,
    parameter int unsigned T_WP_NS       = 50,
    parameter int unsigned T_AW_NS       = 60,
    parameter int unsigned T_DS_NS       = 30,
    parameter int unsigned T_DH_NS       = 5,
    parameter int unsigned T_HZ_NS       = 25,
    parameter int unsigned T_RC_NS       = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int unsigned N_RD = max_u(ns_to_cycles(T_ACC_NS, CLK_PERIOD_NS),
                                         ns_to_cycles(T_OE_ACC_NS, CLK_PERIOD_NS));
    localparam int unsigned N_WL = max_u(max_u(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                               ns_to_cycles(T_AW_NS, CLK_PERIOD_NS)),
                                         ns_to_cycles(T_DS_NS, CLK_PERIOD_NS));
    localparam int unsigned N_DH = ns_to_cycles(T_DH_NS, CLK_PERIOD_NS);
    localparam int unsigned N_HZ = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam int unsigned N_RC = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned N_MAX = max_u(max_u(max_u(N_RD, N_WL), max_u(N_DH, N_HZ)), N_RC);
    localparam int          CNT_W = $clog2(N_MAX + 1);

    logic accept;
    logic capture;

    sram_seq_fsm #(
        .N_RD  (N_RD),
        .N_WL  (N_WL),
        .N_DH  (N_DH),
        .N_HZ  (N_HZ),
        .N_RC  (N_RC),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .ce_n      (sram_ce_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n),
        .drive_en  (sram_dq_oe)
    );

    sram_bus_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .ce_n      (sram_ce_n),
        .dq_in     (sram_dq_in),
        .addr_q    (sram_addr),
        .wdata_q   (sram_dq_out),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    AST_DATA_HELD_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out)); // R5

endmodule

// File: tb/test_sram_cycle_ctrl.sv
// Directed bench for sram_cycle_ctrl with a cycle-counting memory model.
module test_sram_cycle_ctrl;

    localparam int AW = 11;
    localparam int DW = 8;
    // Expected cycle counts at an 8 ns clock, rounded up by hand.
    localparam int E_RD = 9;   // max(70/8 -> 9, 35/8 -> 5)
    localparam int E_WL = 8;   // max(50/8 -> 7, 60/8 -> 8, 30/8 -> 4)
    localparam int E_DH = 1;   // 5/8 -> 1
    localparam int E_HZ = 4;   // 25/8 -> 4
    localparam int E_RC = 9;   // 70/8 -> 9

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out, sram_dq_in;

    always #4 clk = ~clk;

    sram_cycle_ctrl i_sram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // ---------------- memory model ----------------
    logic [DW-1:0] mem [0:2047];
    logic [DW-1:0] shadow [0:2047];
    int            low_cnt = 0;
    int            hz_left = 0;
    logic          pend = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic [DW-1:0] pend_d = '0;
    logic          mdl_rd, mdl_drv;
    logic [DW-1:0] mdl_q;

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mem[i]    = i[7:0] ^ 8'h5A;
            shadow[i] = i[7:0] ^ 8'h5A;
        end
    end

    assign mdl_rd  = !sram_ce_n && !sram_oe_n && sram_we_n;
    assign mdl_drv = mdl_rd || (hz_left > 0);
    assign mdl_q   = (low_cnt >= E_RD - 1) ? mem[sram_addr] : ~mem[sram_addr];
    assign sram_dq_in = sram_dq_oe ? sram_dq_out : (mdl_drv ? mdl_q : 8'h00);

    always @(posedge clk) begin
        if (mdl_rd) begin
            low_cnt <= low_cnt + 1;
            hz_left <= E_HZ;
        end else begin
            low_cnt <= 0;
            if (hz_left > 0) hz_left <= hz_left - 1;
        end
        if (!sram_we_n && !sram_ce_n) begin
            pend   <= 1'b1;
            pend_a <= sram_addr;
            pend_d <= sram_dq_in;
        end else if (pend) begin
            mem[pend_a] <= pend_d;
            pend        <= 1'b0;
        end
    end

    // ---------------- protocol monitor ----------------
    int cyc = 0, last_acc = -1, min_gap = 1000, n_acc = 0;
    int ce_falls = 0, last_oe_low = -1, min_turn = 1000;
    int viol_oe = 0, viol_addr = 0, contention = 0;
    logic prev_ce = 1'b1, prev_oe_drv = 1'b0, prev_busy = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (req_valid && req_ready) begin
                if (last_acc >= 0 && (cyc - last_acc) < min_gap) min_gap = cyc - last_acc;
                last_acc = cyc;
                n_acc++;
            end
            if (prev_ce && !sram_ce_n) ce_falls++;
            if (sram_dq_oe && !sram_oe_n) viol_oe++;
            if (sram_dq_oe && mdl_drv) contention++;
            if (!sram_oe_n) last_oe_low = cyc;
            if (sram_dq_oe && !prev_oe_drv && last_oe_low >= 0 &&
                (cyc - last_oe_low - 1) < min_turn)
                min_turn = cyc - last_oe_low - 1;
            if ((!sram_ce_n || sram_dq_oe) && prev_busy && sram_addr != prev_addr) viol_addr++;
        end
        prev_ce     = sram_ce_n;
        prev_oe_drv = sram_dq_oe;
        prev_busy   = !sram_ce_n || sram_dq_oe;
        prev_addr   = sram_addr;
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Present a request at a negedge, wait for acceptance, return one negedge after.
    task automatic issue(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && !req_ready; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "ce_n", sram_ce_n, 1);
        chk("R1", "oe_n", sram_oe_n, 1);
        chk("R1", "we_n", sram_we_n, 1);
        chk("R1", "dq_oe", sram_dq_oe, 0);
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "req_ready", req_ready, 1);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int wl = 0, dh = 0, bad_oe = 0, bad_d = 0;
        wait_idle();
        issue(1'b1, a, d);
        req_valid = 1'b0;
        chk("R8", "ready low during write", req_ready, 0);
        chk("R5", "drive at strobe fall", sram_dq_oe, 1);
        while (!sram_we_n && wl < 50) begin
            wl++;
            if (!sram_oe_n || sram_ce_n) bad_oe++;
            if (!sram_dq_oe || sram_dq_out != d) bad_d++;
            @(negedge clk);
        end
        while (sram_dq_oe && dh < 50) begin
            dh++;
            if (sram_dq_out != d) bad_d++;
            @(negedge clk);
        end
        chk("R4", "write strobe cycles", wl, E_WL);
        chk("R4", "oe_n high and ce_n low in write", bad_oe, 0);
        chk("R5", "data hold cycles", dh, E_DH);
        chk("R5", "data value while driven", bad_d, 0);
        @(negedge clk);
        chk("R5", "data landed in memory", int'(mem[a]), int'(d));
        shadow[a] = d;
    endtask

    task automatic t_read(input logic [AW-1:0] a);
        int rl = 0, early = 0;
        wait_idle();
        issue(1'b0, a, 8'h00);
        req_valid = 1'b0;
        chk("R8", "ready low during read", req_ready, 0);
        while (!sram_oe_n && rl < 50) begin
            rl++;
            if (sram_ce_n || !sram_we_n) early++;
            if (rd_valid) early++;
            @(negedge clk);
        end
        chk("R10", "read access cycles", rl, E_RD);
        chk("R2", "strobe levels and no early valid", early, 0);
        chk("R2", "valid on release edge", rd_valid, 1);
        chk("R3", "read data", int'(rd_data), int'(shadow[a]));
        @(negedge clk);
        chk("R2", "valid single cycle", rd_valid, 0);
    endtask

    task automatic t_burst();
        wait_idle();
        for (int i = 0; i < 4; i++) issue(1'b1, AW'(11'h100 + i), DW'(8'h10 + i));
        issue(1'b0, 11'h100, 8'h00);
        issue(1'b1, 11'h200, 8'hC3);
        req_valid = 1'b0;
        for (int i = 0; i < 4; i++) shadow[11'h100 + i] = DW'(8'h10 + i);
        shadow[11'h200] = 8'hC3;
        wait_idle();
        for (int i = 0; i < 4; i++) t_read(AW'(11'h100 + i));
        t_read(11'h200);
    endtask

    task automatic t_held_request();
        int pulses = 0, bad = 0, falls0;
        bit go = 1'b0;
        logic [DW-1:0] d1 = '0, d2 = '0;
        wait_idle();
        falls0 = ce_falls;
        issue(1'b0, 11'h033, 8'h00);
        req_addr = 11'h644;
        for (int c = 0; c < 100 && pulses < 2; c++) begin
            if (go) req_valid = 1'b0;
            if (req_ready && req_valid) go = 1'b1;
            if (!sram_ce_n && pulses == 0 && sram_addr != 11'h033) bad++;
            if (rd_valid) begin
                if (pulses == 0) d1 = rd_data; else d2 = rd_data;
                pulses++;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R9", "held fields kept off pins", bad, 0);
        chk("R9", "first read data", int'(d1), int'(shadow[11'h033]));
        chk("R9", "held read data", int'(d2), int'(shadow[11'h644]));
        chk("R9", "access count", ce_falls - falls0, 2);
    endtask

    task automatic t_final();
        chk("R6", "address changes while busy", viol_addr, 0);
        chk("R7", "drive while oe_n low", viol_oe, 0);
        chk("R7", "bus contention with memory", contention, 0);
        chk("R7", "turnaround at least N_HZ", int'(min_turn >= E_HZ), 1);
        chk("R8", "access spacing at least N_RC", int'(min_gap >= E_RC), 1);
        chk("R9", "one access per acceptance", ce_falls, n_acc);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog all actual=%0d expected=finish", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(11'h005, 8'hA5);
        t_read(11'h005);
        t_read(11'h7FF);
        t_write(11'h7FF, 8'h3C);
        t_read(11'h7FF);
        t_write(11'h000, 8'hFF);
        t_read(11'h000);
        t_burst();
        t_held_request();
        t_final();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule